// File: doc/BRIEF.md
# Lockstep Master/Checker Bus Comparator

This block is one half of a redundant pair of processing units that run in lockstep on identical operation streams. Each unit holds a small deterministic datapath (an accumulator with add, xor, rotate and load operations) standing in for a real core. Every operation produces one bus write cycle carrying a 64-bit data word and a 32-bit address. A role input picks how the unit behaves. In master role it drives the bus, together with even parity per data byte and one parity bit over the address. In checker role it keeps every bus output at zero with the output enable low, but it still computes the same results internally.

Both units watch the bus as it is actually driven. The checker compares the observed strobe, address and data with its own shadow results and raises a sticky compare flag on any disagreement. Either role checks the observed parity and records failures in a sticky per-lane mask: eight data lanes and the address lane. All flags stay set until a synchronous clear.

Top module: `fr_lockstep_unit`

## Requirements
- R1: An operation accepted with `op_valid` high updates the accumulator as follows: `op_code` 0 adds the operand, 1 xors it, 2 rotates the accumulator left by one byte, and 3 loads the operand. It also emits a bus cycle whose strobe is high for exactly the one cycle after the accepting edge.
- R2: In master role (`role_checker`=0), `bus_oe` is 1 and the bus outputs carry the core's strobe, address and data, with the new accumulator value as data.
- R3: In checker role (`role_checker`=1), `bus_oe` is 0 and every bus output (strobe, address, data, both parity fields) is held at zero.
- R4: In checker role, a cycle with `bus_strobe_in` high whose observed address or data differs from the unit's own result sets `err_cmp` at the next clock edge.
- R5: In checker role, a cycle where `bus_strobe_in` disagrees with the unit's own strobe sets `err_cmp`. A cycle where both are low is ignored, whatever the other bus inputs hold.
- R6: In master role, `err_cmp` never sets.
- R7: Data parity is even per byte: bit i of the parity field is the XOR of data bits 8i+7..8i. In either role, a strobed cycle with a wrong bit i sets `err_par_lanes[i]` and `err_par` at the next edge. Unstrobed cycles are not parity checked.
- R8: Address parity is the XOR of all 32 address bits. A wrong observed value in a strobed cycle sets `err_par_lanes[8]`.
- R9: The error flags are sticky until `err_clear` is sampled high at an edge, which zeroes them. A fault seen in the same cycle as the clear still sets its flag.
- R10: After reset the flags are zero, the accumulator is zero, the bus outputs are zero, and the first bus cycle uses address 0x0000_1000. Each later cycle's address is 8 higher than the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| role_checker | input | 1 | 1 = checker role, 0 = master role |
| op_valid | input | 1 | Operation accepted this cycle |
| op_code | input | 2 | Operation select |
| op_operand | input | 64 | Operation operand |
| err_clear | input | 1 | Synchronous clear of error flags |
| bus_strobe_in | input | 1 | Observed bus strobe |
| bus_addr_in | input | 32 | Observed bus address |
| bus_data_in | input | 64 | Observed bus data |
| bus_dpar_in | input | 8 | Observed per-byte data parity |
| bus_apar_in | input | 1 | Observed address parity |
| bus_oe | output | 1 | Bus output enable |
| bus_strobe_out | output | 1 | Driven bus strobe |
| bus_addr_out | output | 32 | Driven bus address |
| bus_data_out | output | 64 | Driven bus data |
| bus_dpar_out | output | 8 | Driven per-byte data parity |
| bus_apar_out | output | 1 | Driven address parity |
| err_cmp | output | 1 | Sticky compare mismatch flag |
| err_par | output | 1 | Sticky parity error flag (any lane) |
| err_par_lanes | output | 9 | Sticky parity failures, bits 7..0 data bytes, bit 8 address |

## Verification
The bench flips two bits inside one byte, which parity cannot see. A design that compares only through parity would then miss the mismatch, while one that tests the whole word would wrongly flag a parity lane. It flips a single address bit and expects both a compare error and the address lane. It also corrupts only a parity bit and expects no compare error, which exposes a design that folds the parity fields into the comparison. A dropped master strobe and a spurious strobe while the checker is idle both have to be flagged. A design that gates the comparison on the observed strobe alone would miss the first of them. Clearing in the same cycle as a new fault, and hitting a corrupt parity while the master is in master role, show whether the clear wins wrongly or the comparison runs in the wrong role.

// File: rtl/fr_pkg.sv
package fr_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_XOR  = 2'd1,
        OP_ROTL = 2'd2,
        OP_LOAD = 2'd3
    } op_e;

endpackage

// File: rtl/fr_parity_gen.sv
module fr_parity_gen #(
    parameter int W   = 64,
    parameter int SEG = 8
) (
    input  logic [W-1:0]     vec,
    output logic [W/SEG-1:0] par
);
    localparam int NSEG = W / SEG;

    // Even parity per segment: parity bit makes segment plus bit even.
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        assign par[g] = ^vec[g*SEG +: SEG];
    end
endmodule

// File: rtl/fr_lockstep_core.sv
module fr_lockstep_core
    import fr_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int LANE_W = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic [DATA_W-1:0] op_operand,
    output logic              core_strobe,
    output logic [ADDR_W-1:0] core_addr,
    output logic [DATA_W-1:0] core_data
);
    localparam int NLANES = DATA_W / LANE_W;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(NLANES);

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] addr;
        logic              strobe;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (op_valid) begin
            case (op_e'(op_code))
                OP_ADD:  st_d.acc = st_q.acc + op_operand;
                OP_XOR:  st_d.acc = st_q.acc ^ op_operand;
                OP_ROTL: st_d.acc = {st_q.acc[DATA_W-LANE_W-1:0],
                                     st_q.acc[DATA_W-1 -: LANE_W]};
                default: st_d.acc = op_operand;
            endcase
            st_d.addr   = st_q.ptr;
            st_d.ptr    = st_q.ptr + STEP;
            st_d.strobe = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.acc    <= '0;
            st_q.ptr    <= BASE_ADDR;
            st_q.addr   <= '0;
            st_q.strobe <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign core_strobe = st_q.strobe;
    assign core_addr   = st_q.addr;
    assign core_data   = st_q.acc;
endmodule

// File: rtl/fr_fault_monitor.sv
module fr_fault_monitor #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int LANE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     compare_en,
    input  logic                     err_clear,
    input  logic                     own_strobe,
    input  logic [ADDR_W-1:0]        own_addr,
    input  logic [DATA_W-1:0]        own_data,
    input  logic                     obs_strobe,
    input  logic [ADDR_W-1:0]        obs_addr,
    input  logic [DATA_W-1:0]        obs_data,
    input  logic [DATA_W/LANE_W-1:0] obs_dpar,
    input  logic                     obs_apar,
    output logic                     err_cmp,
    output logic [DATA_W/LANE_W:0]   err_lanes
);
    localparam int NLANES = DATA_W / LANE_W;

    typedef struct packed {
        logic              cmp;
        logic [NLANES:0]   lanes;
    } mon_st_t;

    mon_st_t st_d, st_q;

    logic [NLANES-1:0] dpar_calc;
    logic [0:0]        apar_calc;
    logic              mismatch;
    logic [NLANES:0]   lane_bad;

    fr_parity_gen #(.W(DATA_W), .SEG(LANE_W)) u_dchk (
        .vec (obs_data),
        .par (dpar_calc)
    );

    fr_parity_gen #(.W(ADDR_W), .SEG(ADDR_W)) u_achk (
        .vec (obs_addr),
        .par (apar_calc)
    );

    always_comb begin
        mismatch = compare_en &&
                   ((obs_strobe != own_strobe) ||
                    (obs_strobe && ((obs_addr != own_addr) ||
                                    (obs_data != own_data))));
        lane_bad = {apar_calc[0] ^ obs_apar, dpar_calc ^ obs_dpar}
                   & {(NLANES+1){obs_strobe}};

        st_d = err_clear ? '0 : st_q;
        st_d.cmp   = st_d.cmp | mismatch;
        st_d.lanes = st_d.lanes | lane_bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_cmp   = st_q.cmp;
    assign err_lanes = st_q.lanes;
endmodule

// File: rtl/fr_lockstep_unit.sv
module fr_lockstep_unit #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int LANE_W = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     role_checker,
    input  logic                     op_valid,
    input  logic [1:0]               op_code,
    input  logic [DATA_W-1:0]        op_operand,
    input  logic                     err_clear,
    input  logic                     bus_strobe_in,
    input  logic [ADDR_W-1:0]        bus_addr_in,
    input  logic [DATA_W-1:0]        bus_data_in,
    input  logic [DATA_W/LANE_W-1:0] bus_dpar_in,
    input  logic                     bus_apar_in,
    output logic                     bus_oe,
    output logic                     bus_strobe_out,
    output logic [ADDR_W-1:0]        bus_addr_out,
    output logic [DATA_W-1:0]        bus_data_out,
    output logic [DATA_W/LANE_W-1:0] bus_dpar_out,
    output logic                     bus_apar_out,
    output logic                     err_cmp,
    output logic                     err_par,
    output logic [DATA_W/LANE_W:0]   err_par_lanes
);
    localparam int NLANES = DATA_W / LANE_W;

    logic              core_strobe;
    logic [ADDR_W-1:0] core_addr;
    logic [DATA_W-1:0] core_data;
    logic [NLANES-1:0] core_dpar;
    logic [0:0]        core_apar;

    fr_lockstep_core #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANE_W(LANE_W), .BASE_ADDR(BASE_ADDR)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid    (op_valid),
        .op_code     (op_code),
        .op_operand  (op_operand),
        .core_strobe (core_strobe),
        .core_addr   (core_addr),
        .core_data   (core_data)
    );

    fr_parity_gen #(.W(DATA_W), .SEG(LANE_W)) u_dgen (
        .vec (core_data),
        .par (core_dpar)
    );

    fr_parity_gen #(.W(ADDR_W), .SEG(ADDR_W)) u_agen (
        .vec (core_addr),
        .par (core_apar)
    );

    fr_fault_monitor #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANE_W(LANE_W)
    ) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .compare_en (role_checker),
        .err_clear  (err_clear),
        .own_strobe (core_strobe),
        .own_addr   (core_addr),
        .own_data   (core_data),
        .obs_strobe (bus_strobe_in),
        .obs_addr   (bus_addr_in),
        .obs_data   (bus_data_in),
        .obs_dpar   (bus_dpar_in),
        .obs_apar   (bus_apar_in),
        .err_cmp    (err_cmp),
        .err_lanes  (err_par_lanes)
    );

    // Checker role: drivers disabled and outputs parked at zero.
    always_comb begin
        bus_oe = !role_checker;
        if (role_checker) begin
            bus_strobe_out = 1'b0;
            bus_addr_out   = '0;
            bus_data_out   = '0;
            bus_dpar_out   = '0;
            bus_apar_out   = 1'b0;
        end else begin
            bus_strobe_out = core_strobe;
            bus_addr_out   = core_addr;
            bus_data_out   = core_data;
            bus_dpar_out   = core_dpar;
            bus_apar_out   = core_apar[0];
        end
    end

    assign err_par = |err_par_lanes;
endmodule

// File: rtl/fr_lockstep_unit_chk.sv
module fr_lockstep_unit_chk #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              role_checker,
    input logic              op_valid,
    input logic              err_clear,
    input logic              bus_strobe_in,
    input logic              bus_oe,
    input logic              bus_strobe_out,
    input logic [ADDR_W-1:0] bus_addr_out,
    input logic [DATA_W-1:0] bus_data_out,
    input logic              core_strobe,
    input logic              err_cmp,
    input logic              err_par
);
    // R1
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> core_strobe);
    // R1
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !core_strobe);
    // R2
    master_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !role_checker |-> (bus_oe && (bus_strobe_out == core_strobe)));
    // R3
    checker_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        role_checker |-> (!bus_oe && !bus_strobe_out &&
                          bus_addr_out == '0 && bus_data_out == '0));
    // R5
    idle_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_strobe_in && !core_strobe && !err_cmp) |=> !err_cmp);
    // R6
    master_no_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!role_checker && !err_cmp) |=> !err_cmp);
    // R9
    sticky_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cmp && !err_clear) |=> err_cmp);
    // R9
    sticky_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_par && !err_clear) |=> err_par);
    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clear && !bus_strobe_in && !core_strobe) |=> (!err_cmp && !err_par));
endmodule

bind fr_lockstep_unit fr_lockstep_unit_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .role_checker   (role_checker),
    .op_valid       (op_valid),
    .err_clear      (err_clear),
    .bus_strobe_in  (bus_strobe_in),
    .bus_oe         (bus_oe),
    .bus_strobe_out (bus_strobe_out),
    .bus_addr_out   (bus_addr_out),
    .bus_data_out   (bus_data_out),
    .core_strobe    (core_strobe),
    .err_cmp        (err_cmp),
    .err_par        (err_par)
);

// File: tb/tb_fr_lockstep_unit.sv
module tb_fr_lockstep_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        role_checker;
    logic        op_valid;
    logic [1:0]  op_code;
    logic [63:0] op_operand;
    logic        err_clear;
    logic        bus_strobe_in;
    logic [31:0] bus_addr_in;
    logic [63:0] bus_data_in;
    logic [7:0]  bus_dpar_in;
    logic        bus_apar_in;
    logic        bus_oe;
    logic        bus_strobe_out;
    logic [31:0] bus_addr_out;
    logic [63:0] bus_data_out;
    logic [7:0]  bus_dpar_out;
    logic        bus_apar_out;
    logic        err_cmp;
    logic        err_par;
    logic [8:0]  err_par_lanes;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    logic [63:0] m_acc;
    logic [31:0] m_ptr;
    logic [31:0] m_addr;

    always #10 clk = ~clk;

    fr_lockstep_unit dut (.*);

    typedef struct packed {
        logic [1:0]  op;
        logic [63:0] operand;
        logic [63:0] dflip;
        logic [31:0] aflip;
        logic [8:0]  pflip;
        logic        drop;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{2'd3, 64'h0123_4567_89AB_CDEF, 64'h0,     32'h0,  9'h000, 1'b0},
        '{2'd0, 64'h1111_1111_1111_1111, 64'h1,     32'h0,  9'h000, 1'b0},
        '{2'd1, 64'hFF00_FF00_0F0F_F0F0, 64'h0,     32'h0,  9'h020, 1'b0},
        '{2'd2, 64'h0,                   64'h0300,  32'h0,  9'h000, 1'b0},
        '{2'd0, 64'h8000_0000_0000_0001, 64'h0,     32'h10, 9'h000, 1'b0},
        '{2'd3, 64'hDEAD_BEEF_CAFE_F00D, 64'h0,     32'h0,  9'h100, 1'b0},
        '{2'd1, 64'h5555_AAAA_5555_AAAA, 64'h0,     32'h0,  9'h000, 1'b1},
        '{2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,     32'h0,  9'h000, 1'b0}
    };

    function automatic logic [7:0] dpar_of(input logic [63:0] d);
        logic [7:0] p;
        for (int b = 0; b < 8; b++) p[b] = ^d[b*8 +: 8];
        return p;
    endfunction

    function automatic logic [63:0] next_acc(input logic [1:0] op,
                                             input logic [63:0] a,
                                             input logic [63:0] b);
        case (op)
            2'd0:    return a + b;
            2'd1:    return a ^ b;
            2'd2:    return {a[55:0], a[63:56]};
            default: return b;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_idle();
        bus_strobe_in = 1'b0;
        bus_addr_in   = '0;
        bus_data_in   = '0;
        bus_dpar_in   = '0;
        bus_apar_in   = 1'b0;
    endtask

    task automatic do_reset(input logic role);
        role_checker = role;
        rst_n        = 1'b0;
        op_valid     = 1'b0;
        op_code      = '0;
        op_operand   = '0;
        err_clear    = 1'b0;
        bus_idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_acc = '0;
        m_ptr = 32'h0000_1000;
        m_addr = '0;
    endtask

    // Issue one op; returns at the negedge where its bus cycle is visible.
    task automatic issue(input logic [1:0] op, input logic [63:0] operand);
        @(negedge clk);
        op_valid   = 1'b1;
        op_code    = op;
        op_operand = operand;
        m_acc  = next_acc(op, m_acc, operand);
        m_addr = m_ptr;
        m_ptr  = m_ptr + 32'd8;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic clear_flags();
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        chk(!err_cmp && err_par_lanes == 9'h0, "R9 clear",
            {55'h0, err_cmp, err_par_lanes}, 64'h0);
    endtask

    task automatic run_vec(input vec_t v);
        logic [8:0] exp_lanes;
        logic       exp_cmp;
        issue(v.op, v.operand);
        chk(!bus_oe && !bus_strobe_out && bus_data_out == '0 &&
            bus_addr_out == '0 && bus_dpar_out == '0 && !bus_apar_out,
            "R3 checker outputs parked", bus_data_out, 64'h0);
        bus_strobe_in = !v.drop;
        bus_addr_in   = m_addr ^ v.aflip;
        bus_data_in   = m_acc ^ v.dflip;
        bus_dpar_in   = dpar_of(m_acc) ^ v.pflip[7:0];
        bus_apar_in   = (^m_addr) ^ v.pflip[8];
        exp_cmp   = v.drop || (v.dflip != 0) || (v.aflip != 0);
        exp_lanes = v.drop ? 9'h0 :
                    ({^v.aflip, dpar_of(v.dflip)} ^ v.pflip);
        @(negedge clk);
        bus_idle();
        chk(err_cmp == exp_cmp, "R4/R5 compare flag", {63'h0, err_cmp},
            {63'h0, exp_cmp});
        chk(err_par_lanes == exp_lanes && err_par == (exp_lanes != 0),
            "R7/R8 parity lanes", {55'h0, err_par_lanes}, {55'h0, exp_lanes});
        clear_flags();
    endtask

    initial begin
        // R10: reset state, checker role
        do_reset(1'b1);
        @(negedge clk);
        chk(!err_cmp && !err_par && err_par_lanes == 9'h0, "R10 flags after reset",
            {55'h0, err_par_lanes}, 64'h0);
        chk(!bus_oe && !bus_strobe_out, "R3 R10 bus disabled after reset",
            {63'h0, bus_oe}, 64'h0);

        // Vector table: R1 datapath, R4/R5 compare, R7/R8 parity, R10 addresses
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R5: spurious observed strobe while own core idle
        @(negedge clk);
        bus_strobe_in = 1'b1;
        @(negedge clk);
        bus_idle();
        chk(err_cmp && err_par_lanes == 9'h0, "R5 spurious strobe",
            {55'h0, err_cmp, err_par_lanes}, 64'h200);
        // R9: sticky over idle cycles
        repeat (5) @(negedge clk);
        chk(err_cmp, "R9 sticky", {63'h0, err_cmp}, 64'h1);
        // R9: fault in the clear cycle still sets
        err_clear     = 1'b1;
        bus_strobe_in = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        bus_idle();
        chk(err_cmp, "R9 fault beats clear", {63'h0, err_cmp}, 64'h1);
        clear_flags();

        // R5/R7: idle cycle with garbage is ignored
        bus_data_in = 64'hFFFF_0000_1234_5678;
        bus_addr_in = 32'hABCD_0001;
        bus_dpar_in = 8'h5A;
        bus_apar_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_idle();
        chk(!err_cmp && !err_par, "R5 R7 idle ignored",
            {55'h0, err_cmp, err_par_lanes}, 64'h0);

        // Master role
        do_reset(1'b0);
        @(negedge clk);
        chk(bus_oe && !bus_strobe_out && bus_addr_out == '0 && bus_data_out == '0,
            "R10 R2 master reset outputs", bus_data_out, 64'h0);
        issue(2'd3, 64'hA5A5_0000_FFFF_1234);
        chk(bus_oe && bus_strobe_out && bus_addr_out == 32'h0000_1000,
            "R2 R10 master address", {32'h0, bus_addr_out}, 64'h1000);
        chk(bus_data_out == m_acc, "R2 R1 master data", bus_data_out, m_acc);
        chk(bus_dpar_out == dpar_of(m_acc), "R7 driven data parity",
            {56'h0, bus_dpar_out}, {56'h0, dpar_of(m_acc)});
        chk(bus_apar_out == ^m_addr, "R8 driven address parity",
            {63'h0, bus_apar_out}, {63'h0, ^m_addr});
        bus_strobe_in = 1'b1;
        bus_addr_in   = m_addr;
        bus_data_in   = m_acc ^ 64'h0001_0000;
        bus_dpar_in   = dpar_of(m_acc);
        bus_apar_in   = ^m_addr;
        @(negedge clk);
        bus_idle();
        chk(!bus_strobe_out, "R1 strobe one cycle", {63'h0, bus_strobe_out}, 64'h0);
        chk(!err_cmp, "R6 master no compare", {63'h0, err_cmp}, 64'h0);
        chk(err_par_lanes == 9'h004, "R7 master parity lane 2",
            {55'h0, err_par_lanes}, 64'h4);
        // R6: spurious strobe in master role
        bus_strobe_in = 1'b1;
        @(negedge clk);
        bus_idle();
        chk(!err_cmp, "R6 master spurious strobe", {63'h0, err_cmp}, 64'h0);
        // R1: rotate then add in master role
        issue(2'd2, 64'h0);
        chk(bus_data_out == m_acc && bus_addr_out == 32'h0000_1008,
            "R1 R10 rotate and next address", bus_data_out, m_acc);
        issue(2'd0, 64'h0000_0000_0000_0100);
        chk(bus_data_out == m_acc, "R1 add", bus_data_out, m_acc);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule